// File: doc/BRIEF.md
# Scan-Chain Debug Register Bank

This block holds the debug registers of a core and makes them reachable from a test access port through one data-register scan chain. The host shifts a 38-bit frame least significant bit first. The frame carries a 32-bit data word in bits 31:0, a 5-bit register address in bits 36:32 and a direction flag in bit 37. When the update strobe arrives, a flag of 1 stores the data word into the addressed register. A flag of 0 selects that address for reading. The selected register is loaded into the data field at the next capture, so every read costs two scans. A second scan that names the communications control register is a safe way to finish a read.

The registers are:
- A debug control register that drives the core's debug controls.
- A read-only debug status register taken from the core.
- A vector-catch register.
- A configurable number of watchpoint units, each with six 32-bit value and mask registers.
- A host-to-core and core-to-host message channel, with a control word that reports both mailbox flags and a version number.

Capturing the message data register is a destructive read: it empties the core-to-host mailbox. The core side fills that mailbox and drains the other one through plain strobes.

Top module: `dbg_scan_regbank`

## Requirements
- R1: The chain is 38 bits wide. In each shift cycle it moves one place toward `tdo`, and `tdi` enters at bit 37. `tdo` always shows bit 0, so the frame goes out least significant bit first. The frame fields are data in bits 31:0, address in bits 36:32 and direction in bit 37.
- R2: At capture the chain loads three fields: bits 31:0 take the contents of the register selected for reading, bits 36:32 take the selected address, and bit 37 takes 0. An update with direction 0 sets the selection to that frame's address. After reset the selection is address 0x00.
- R3: An update with direction 1 writes the data field into the addressed register and leaves the read selection unchanged.
- R4: Watchpoint unit k takes addresses 0x08+8k to 0x0D+8k. Its six registers are, in address order: address value, address mask, data value, data mask, control value, control mask. All six are read/write and appear on `wp_cfg_o`, with unit k, register j at bits [(6k+j)*32 +: 32]. Offsets 6 and 7 within a unit are unmapped. A write to one register leaves the others unchanged.
- R5: Debug control (0x00) keeps only its low CTRL_BITS bits, and the upper bits read as 0. It resets to CTRL_RESET, which has the monitor-mode enable in bit 4 set. A host write can clear that bit. The stored value drives `ctrl_o`, which changes only on an update.
- R6: Debug status (0x01) reads as `status_i` zero-extended, and host writes to it have no effect.
- R7: Communications control (0x04) reads as follows: bit 0 is the core-to-host full flag, bit 1 is the host-to-core full flag, bits 31:28 are VERSION, and all other bits are 0. Host writes to it are ignored.
- R8: A host write to communications data (0x05) loads `h2c_data_o` and sets the host-to-core full flag. A `core_ack_i` pulse clears that flag.
- R9: A `core_wr_i` pulse loads `core_wdata_i` into the core-to-host word and sets its full flag. A capture with 0x05 selected returns that word and clears the flag. A capture of any other address leaves the flag unchanged.
- R10: When a set and a clear of the same mailbox flag fall in one cycle, the set wins. A capture that collides with `core_wr_i` returns the old word, leaves the flag set and keeps the new word for the next read.
- R11: Vector catch (0x02) stores its low VC_BITS bits, reads the upper bits as 0, and drives `vcatch_o`.
- R12: Addresses outside the map read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_dr | input | 1 | Load read word into the chain |
| shift_dr | input | 1 | Shift chain one bit |
| update_dr | input | 1 | Act on the shifted frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| status_i | input | STAT_BITS | Core debug status |
| core_wr_i | input | 1 | Core pushes a word to the host |
| core_wdata_i | input | 32 | Word pushed by the core |
| core_ack_i | input | 1 | Core has consumed the host word |
| h2c_data_o | output | 32 | Last word written by the host |
| h2c_full_o | output | 1 | Host-to-core mailbox full |
| c2h_full_o | output | 1 | Core-to-host mailbox full |
| ctrl_o | output | CTRL_BITS | Debug control bits |
| vcatch_o | output | VC_BITS | Vector-catch bits |
| wp_cfg_o | output | NUM_WP*192 | All watchpoint registers |

## Verification
Each mailbox flag can be set and cleared in the same cycle. For the core-to-host flag this happens when `core_wr_i` coincides with the capture that drains the flag. For the host-to-core flag it happens when `core_ack_i` coincides with the update that writes 0x05. The bench raises the core strobe exactly in the capture cycle, or exactly in the update cycle, of a scan. It then checks that the flag on the port is still set. It also checks that the colliding read returned the older word, and that a later read returns the newer one.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int FRAME_W  = DATA_W + ADDR_W + 1;
    localparam int WP_REGS  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h01;
    localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
    localparam logic [ADDR_W-1:0] A_MCTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] A_MDATA  = 5'h05;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture_dr,
    input  logic   shift_dr,
    input  logic   tdi,
    input  frame_t cap_word,
    output frame_t frame_o,
    output logic   tdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_dr) begin
            st_d.sr = cap_word;
        end else if (shift_dr) begin
            st_d.sr = {tdi, st_q.sr[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = frame_t'(st_q.sr);
    assign tdo     = st_q.sr[0];
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_ack,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_full,
    output logic [DATA_W-1:0] c2h_data,
    output logic              c2h_full
);
    typedef struct packed {
        logic [DATA_W-1:0] h2c;
        logic              h2c_f;
        logic [DATA_W-1:0] c2h;
        logic              c2h_f;
    } mb_state_t;

    mb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, sets last: a colliding set wins
        if (core_ack) st_d.h2c_f = 1'b0;
        if (host_wr) begin
            st_d.h2c   = host_wdata;
            st_d.h2c_f = 1'b1;
        end
        if (host_rd) st_d.c2h_f = 1'b0;
        if (core_wr) begin
            st_d.c2h   = core_wdata;
            st_d.c2h_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h2c_data = st_q.h2c;
    assign h2c_full = st_q.h2c_f;
    assign c2h_data = st_q.c2h;
    assign c2h_full = st_q.c2h_f;
endmodule

// File: rtl/dbg_wp_unit.sv
module dbg_wp_unit
    import dbg_scan_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_off,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [2:0]                rd_off,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_valid,
    output logic [WP_REGS*DATA_W-1:0] cfg
);
    typedef struct packed {
        logic [WP_REGS-1:0][DATA_W-1:0] r;
    } wp_state_t;

    wp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_off) < WP_REGS)) begin
            st_d.r[wr_off] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_valid = int'(rd_off) < WP_REGS;
        rd_data  = '0;
        if (rd_valid) rd_data = st_q.r[rd_off];
    end

    assign cfg = st_q.r;
endmodule

// File: rtl/dbg_scan_regbank.sv
module dbg_scan_regbank
    import dbg_scan_pkg::*;
#(
    parameter int             NUM_WP     = 2,
    parameter int             CTRL_BITS  = 6,
    parameter int             STAT_BITS  = 5,
    parameter int             VC_BITS    = 8,
    parameter logic [3:0]     VERSION    = 4'd5,
    parameter logic [CTRL_BITS-1:0] CTRL_RESET = CTRL_BITS'(6'b010000)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            capture_dr,
    input  logic                            shift_dr,
    input  logic                            update_dr,
    input  logic                            tdi,
    output logic                            tdo,
    input  logic [STAT_BITS-1:0]            status_i,
    input  logic                            core_wr_i,
    input  logic [31:0]                     core_wdata_i,
    input  logic                            core_ack_i,
    output logic [31:0]                     h2c_data_o,
    output logic                            h2c_full_o,
    output logic                            c2h_full_o,
    output logic [CTRL_BITS-1:0]            ctrl_o,
    output logic [VC_BITS-1:0]              vcatch_o,
    output logic [NUM_WP*WP_REGS*32-1:0]    wp_cfg_o
);
    localparam int UNIT_W = WP_REGS * DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0]    rd_sel;
        logic [CTRL_BITS-1:0] ctrl;
        logic [VC_BITS-1:0]   vc;
    } top_state_t;

    top_state_t st_d, st_q;
    frame_t     frame_q;
    frame_t     cap_word;
    logic       upd_wr;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] c2h_word;
    logic [NUM_WP-1:0]             wp_hit;
    logic [NUM_WP-1:0][DATA_W-1:0] wp_rd;
    logic [NUM_WP-1:0]             wp_rd_ok;

    assign upd_wr = update_dr && frame_q.wr;

    dbg_scan_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_word   (cap_word),
        .frame_o    (frame_q),
        .tdo        (tdo)
    );

    dbg_mailbox u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (upd_wr && (frame_q.addr == A_MDATA)),
        .host_wdata (frame_q.data),
        .host_rd    (capture_dr && (st_q.rd_sel == A_MDATA)),
        .core_wr    (core_wr_i),
        .core_wdata (core_wdata_i),
        .core_ack   (core_ack_i),
        .h2c_data   (h2c_data_o),
        .h2c_full   (h2c_full_o),
        .c2h_data   (c2h_word),
        .c2h_full   (c2h_full_o)
    );

    for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
        localparam logic [1:0] BANK = 2'(k + 1);
        assign wp_hit[k] = (st_q.rd_sel[4:3] == BANK);
        dbg_wp_unit u_wp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (upd_wr && (frame_q.addr[4:3] == BANK)),
            .wr_off   (frame_q.addr[2:0]),
            .wr_data  (frame_q.data),
            .rd_off   (st_q.rd_sel[2:0]),
            .rd_data  (wp_rd[k]),
            .rd_valid (wp_rd_ok[k]),
            .cfg      (wp_cfg_o[k*UNIT_W +: UNIT_W])
        );
    end

    // next-state of selection and local registers
    always_comb begin
        st_d = st_q;
        if (update_dr) begin
            if (!frame_q.wr) begin
                st_d.rd_sel = frame_q.addr;
            end else begin
                case (frame_q.addr)
                    A_CTRL:   st_d.ctrl = frame_q.data[CTRL_BITS-1:0];
                    A_VCATCH: st_d.vc   = frame_q.data[VC_BITS-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_sel <= A_CTRL;
            st_q.ctrl   <= CTRL_RESET;
            st_q.vc     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read multiplexer for the selected address
    always_comb begin
        rdata = '0;
        case (st_q.rd_sel)
            A_CTRL:   rdata[CTRL_BITS-1:0] = st_q.ctrl;
            A_STAT:   rdata[STAT_BITS-1:0] = status_i;
            A_VCATCH: rdata[VC_BITS-1:0]   = st_q.vc;
            A_MCTRL:  rdata = {VERSION, 26'd0, h2c_full_o, c2h_full_o};
            A_MDATA:  rdata = c2h_word;
            default: begin
                for (int k = 0; k < NUM_WP; k++) begin
                    if (wp_hit[k] && wp_rd_ok[k]) rdata = wp_rd[k];
                end
            end
        endcase
    end

    always_comb begin
        cap_word.wr   = 1'b0;
        cap_word.addr = st_q.rd_sel;
        cap_word.data = rdata;
    end

    assign ctrl_o   = st_q.ctrl;
    assign vcatch_o = st_q.vc;
endmodule

// File: rtl/dbg_scan_regbank_chk.sv
module dbg_scan_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        capture_dr,
    input logic        shift_dr,
    input logic        update_dr,
    input logic        tdi,
    input logic [37:0] frame,
    input logic [4:0]  rd_sel,
    input logic        core_wr_i,
    input logic        core_ack_i,
    input logic        h2c_full_o,
    input logic        c2h_full_o,
    input logic [5:0]  ctrl_o
);
    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> frame[37] == $past(tdi));

    a_r2_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr |=> (frame[36:32] == $past(rd_sel)) && !frame[37]);

    a_r3_write_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (update_dr && frame[37]) |=> $stable(rd_sel));

    a_r5_ctrl_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !update_dr |=> $stable(ctrl_o));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack_i && !(update_dr && frame[37] && frame[36:32] == 5'h05)) |=> !h2c_full_o);

    a_r9_core_sets: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_i |=> c2h_full_o);
endmodule

bind dbg_scan_regbank dbg_scan_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .frame      (frame_q),
    .rd_sel     (st_q.rd_sel),
    .core_wr_i  (core_wr_i),
    .core_ack_i (core_ack_i),
    .h2c_full_o (h2c_full_o),
    .c2h_full_o (c2h_full_o),
    .ctrl_o     (ctrl_o[5:0])
);

// File: tb/tb_dbg_scan_regbank.sv
module tb_dbg_scan_regbank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo;
    logic [4:0]  status_i = 5'h1A;
    logic        core_wr_i = 0;
    logic [31:0] core_wdata_i = '0;
    logic        core_ack_i = 0;
    logic [31:0] h2c_data_o;
    logic        h2c_full_o, c2h_full_o;
    logic [5:0]  ctrl_o;
    logic [7:0]  vcatch_o;
    logic [383:0] wp_cfg_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dbg_scan_regbank dut (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .status_i(status_i),
        .core_wr_i(core_wr_i), .core_wdata_i(core_wdata_i), .core_ack_i(core_ack_i),
        .h2c_data_o(h2c_data_o), .h2c_full_o(h2c_full_o), .c2h_full_o(c2h_full_o),
        .ctrl_o(ctrl_o), .vcatch_o(vcatch_o), .wp_cfg_o(wp_cfg_o)
    );

    // {addr, write data, expected readback}
    localparam logic [68:0] VEC [10] = '{
        {5'h08, 32'h12345678, 32'h12345678},   // R4
        {5'h0D, 32'hCAFEF00D, 32'hCAFEF00D},   // R4
        {5'h10, 32'hA5A5A5A5, 32'hA5A5A5A5},   // R4
        {5'h15, 32'h0F0F0F0F, 32'h0F0F0F0F},   // R4
        {5'h00, 32'hFFFFFFEF, 32'h0000002F},   // R5
        {5'h02, 32'hFFFFFF5A, 32'h0000005A},   // R11
        {5'h0E, 32'hFFFFFFFF, 32'h00000000},   // R4 offset 6
        {5'h1F, 32'h00001234, 32'h00000000},   // R12
        {5'h04, 32'hFFFFFFFF, 32'h50000000},   // R7
        {5'h01, 32'hFFFFFFFF, 32'h0000001A}    // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input logic wr, input logic [4:0] addr, input logic [31:0] data,
                        input bit cwr, input logic [31:0] cdata, input bit ack,
                        output logic [37:0] fout);
        logic [37:0] fin;
        fin = {wr, addr, data};
        @(negedge clk);
        capture_dr = 1; core_wr_i = cwr; core_wdata_i = cdata;
        @(negedge clk);
        capture_dr = 0; core_wr_i = 0; shift_dr = 1;
        for (int i = 0; i < 38; i++) begin
            fout[i] = tdo;
            tdi = fin[i];
            @(negedge clk);
        end
        shift_dr = 0; update_dr = 1; core_ack_i = ack;
        @(negedge clk);
        update_dr = 0; core_ack_i = 0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] f;
        scan(1'b1, a, d, 0, '0, 0, f);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        logic [37:0] f;
        scan(1'b0, a, '0, 0, '0, 0, f);
        scan(1'b0, 5'h04, '0, 0, '0, 0, f);
        d = f[31:0];
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [37:0] f;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R5 ctrl_o reset", {26'd0, ctrl_o}, 32'h10);
        check("R8 h2c reset", {31'd0, h2c_full_o}, 0);
        // first capture after reset returns debug control
        scan(1'b0, 5'h04, '0, 0, '0, 0, f);
        check("R2 reset selection data", f[31:0], 32'h10);
        check("R2 captured addr field", {27'd0, f[36:32]}, 0);
        check("R1 captured flag bit", {31'd0, f[37]}, 0);
        scan(1'b0, 5'h04, '0, 0, '0, 0, f);
        check("R7 comms ctrl at reset", f[31:0], 32'h50000000);
        check("R2 captured addr field 0x04", {27'd0, f[36:32]}, 32'h4);

        for (int v = 0; v < 10; v++) begin
            wr_reg(VEC[v][68:64], VEC[v][63:32]);
            rd_reg(VEC[v][68:64], d);
            check($sformatf("R3/R4/R5/R6/R7/R11/R12 vector %0d", v), d, VEC[v][31:0]);
        end
        check("R5 ctrl_o after write", {26'd0, ctrl_o}, 32'h2F);
        check("R11 vcatch_o", {24'd0, vcatch_o}, 32'h5A);
        check("R4 wp_cfg unit1 ctrl mask", wp_cfg_o[11*32 +: 32], 32'h0F0F0F0F);
        check("R4 wp_cfg unit0 data mask", wp_cfg_o[3*32 +: 32], 32'h0);
        rd_reg(5'h08, d);
        check("R4 neighbour unchanged", d, 32'h12345678);
        rd_reg(5'h0C, d);
        check("R12 unmapped write no effect", d, 32'h0);

        // R3: write leaves selection at 0x08
        scan(1'b0, 5'h08, '0, 0, '0, 0, f);
        wr_reg(5'h09, 32'h00000055);
        scan(1'b0, 5'h04, '0, 0, '0, 0, f);
        check("R3 selection kept over write", f[31:0], 32'h12345678);

        // R9 core-to-host
        @(negedge clk); core_wr_i = 1; core_wdata_i = 32'hDEADBEEF;
        @(negedge clk); core_wr_i = 0;
        check("R9 c2h flag set", {31'd0, c2h_full_o}, 1);
        rd_reg(5'h04, d);
        check("R9 comms ctrl bit0", d, 32'h50000001);
        check("R9 non-data capture keeps flag", {31'd0, c2h_full_o}, 1);
        rd_reg(5'h05, d);
        check("R9 comms data read", d, 32'hDEADBEEF);
        check("R9 flag cleared by read", {31'd0, c2h_full_o}, 0);

        // R8 host-to-core
        wr_reg(5'h05, 32'h600DD00D);
        check("R8 h2c data", h2c_data_o, 32'h600DD00D);
        check("R8 h2c flag", {31'd0, h2c_full_o}, 1);
        rd_reg(5'h04, d);
        check("R8 comms ctrl bit1", d, 32'h50000002);
        @(negedge clk); core_ack_i = 1;
        @(negedge clk); core_ack_i = 0;
        check("R8 ack clears", {31'd0, h2c_full_o}, 0);

        // R10 collisions
        @(negedge clk); core_wr_i = 1; core_wdata_i = 32'h11111111;
        @(negedge clk); core_wr_i = 0;
        scan(1'b0, 5'h05, '0, 0, '0, 0, f);
        scan(1'b0, 5'h04, '0, 1, 32'h22222222, 0, f);
        check("R10 colliding read old word", f[31:0], 32'h11111111);
        check("R10 c2h set wins", {31'd0, c2h_full_o}, 1);
        rd_reg(5'h05, d);
        check("R10 new word kept", d, 32'h22222222);
        check("R10 flag cleared after", {31'd0, c2h_full_o}, 0);
        scan(1'b1, 5'h05, 32'h33333333, 0, '0, 1, f);
        check("R10 h2c set wins", {31'd0, h2c_full_o}, 1);
        check("R10 h2c data", h2c_data_o, 32'h33333333);

        // R6 status follows input, R5 monitor bit cleared
        status_i = 5'h05;
        rd_reg(5'h01, d);
        check("R6 status follows input", d, 32'h5);
        check("R5 monitor bit clear", {31'd0, ctrl_o[4]}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule